// File: doc/BRIEF.md
# Streaming Binary Mask Morphology Sequencer

This block cleans a streamed binary foreground mask, one bit per pixel in raster order, by applying one of four morphological operators with a 3×3 structuring element. The four operators are dilation, erosion, closing and opening. Every operator is built from a single primitive, which is dilation. Erosion comes from complementing the mask before a dilation pass and complementing the result after it. Closing and opening cascade a second, identical dilation pass behind the first, with a complement between the two passes. Pixel value 1 means foreground and 0 means background.

Both passes advance in lockstep on one shared tick. A single frame tracker counts these ticks from the frame-start beat. From that count it derives the centre row and column of each pass. The row and column tell each pass when its output is a real pixel and which window neighbours lie outside the frame. After the last input pixel, the tracker injects flush ticks on its own until the selected pass depth has emptied. No trailing input is needed.

Top module: `morph_seq`

## Requirements
- R1: While reset is applied, and after its release until a frame has been accepted, `out_valid` stays 0.
- R2: With `{sel_pair,sel_inv}` = 00 the output pixel at (r,c) is 1 exactly when some bit i of `se_mask` is set and the pixel at (r+i/3-1, c+i%3-1) lies inside the frame and is 1. Bit 4 is the window centre.
- R3: With select 01 the output is the complement of the R2 dilation applied to the complemented mask. This is erosion.
- R4: With select 10 the output is the R3 erosion of the R2 dilation of the mask. This is closing.
- R5: With select 11 the output is the R2 dilation of the R3 erosion of the mask. This is opening.
- R6: In every dilation pass, neighbour positions outside the frame contribute nothing. As a result, an erosion keeps border pixels whose in-frame neighbours are all foreground.
- R7: Each frame yields exactly IMG_W*IMG_H output beats in raster order. With input valid on every cycle, the first output beat follows the frame-start beat by IMG_W+1 clock cycles for single-pass operators and by 2*IMG_W+3 cycles for two-pass operators.
- R8: Cycles without `in_valid` during a frame only stall processing. The filtered result is the same as for an unbroken stream.
- R9: `sel_inv`, `sel_pair` and `se_mask` are captured on the frame-start beat. Changes to them later in the frame have no effect on that frame.
- R10: A frame-start beat that arrives while a frame is in progress abandons the old frame and begins a new one. All outputs that follow belong to the new frame.
- R11: Valid beats without frame start that arrive when no pixel is expected are ignored. This covers both the idle state and the flush after the last pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | Marks the first pixel of a frame (qualified by in_valid) |
| in_tag | input | 1 | Input mask bit, 1 = foreground |
| se_mask | input | 9 | Structuring element, bit (dr+1)*3+(dc+1) enables offset (dr,dc) |
| sel_inv | input | 1 | First select bit: complement the mask before the first pass |
| sel_pair | input | 1 | Second select bit: chain the second pass |
| out_valid | output | 1 | Output pixel strobe |
| out_tag | output | 1 | Filtered mask bit |

## Verification
The bench targets the frame edges. A lone corner pixel, and an all-foreground frame under erosion, both expose a design that wraps neighbours across rows or treats the outside of the frame as background. Such a design would smear a pixel onto the opposite edge or eat the border. An asymmetric structuring element catches a mirrored or misnumbered window bit, because the dilated blob would land on the wrong side. Streams with stalls, noise beats during flush, a mid-frame restart and select changes just after frame start show whether a design advances on the wrong cycles, drops or duplicates beats, or reads controls late. Measured first-output latency separates single-pass from two-pass routing.

// File: rtl/morph_pkg.sv
package morph_pkg;

  // Operator code, packed as {sel_pair, sel_inv}
  typedef enum logic [1:0] {
    OP_DILATE = 2'b00,
    OP_ERODE  = 2'b01,
    OP_CLOSE  = 2'b10,
    OP_OPEN   = 2'b11
  } morph_op_e;

  // Which frame borders the current window centre touches
  typedef struct packed {
    logic top;
    logic bot;
    logic lft;
    logic rgt;
  } edge_t;

  localparam int NUM_PASS = 2;

endpackage

// File: rtl/morph_frame_track.sv
module morph_frame_track
  import morph_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 8,
  parameter int NSTG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             two_pass,
  output logic             adv,
  output logic             take,
  output logic             act,
  output logic             feed,
  output logic [NSTG-1:0]  cv,
  output edge_t [NSTG-1:0] edg
);

  localparam int NPIX  = IMG_W * IMG_H;
  localparam int LAST1 = NPIX + IMG_W;          // last tick, one pass
  localparam int LAST2 = NPIX + 2 * IMG_W + 2;  // last tick, two passes
  localparam int TW    = $clog2(NPIX + 2 * IMG_W + 4);
  localparam int RW    = (IMG_H > 2) ? $clog2(IMG_H) : 1;
  localparam int CW    = (IMG_W > 2) ? $clog2(IMG_W) : 1;

  logic          start;
  logic          act_q, act_d;
  logic [TW-1:0] t_q, t_d, kidx, last;

  assign start = in_valid & in_sof;
  assign act   = act_q;
  assign feed  = act_q & (t_q < TW'(NPIX));
  assign adv   = start | (act_q & (~feed | in_valid));
  assign take  = start | (feed & in_valid);
  assign kidx  = start ? '0 : t_q;
  assign last  = two_pass ? TW'(LAST2) : TW'(LAST1);

  always_comb begin
    act_d = act_q;
    t_d   = t_q;
    if (start) begin
      act_d = 1'b1;
      t_d   = TW'(1);
    end else if (act_q && adv) begin
      t_d = t_q + TW'(1);
      if (t_q == last) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      t_q   <= '0;
    end else begin
      act_q <= act_d;
      if (adv) t_q <= t_d;
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    localparam int OFF = (s + 1) * (IMG_W + 1) + s;

    logic [RW-1:0] cr_q, cr_d;
    logic [CW-1:0] cc_q, cc_d;

    assign cv[s] = adv && (int'(kidx) >= OFF) && (int'(kidx) < OFF + NPIX);

    always_comb begin
      cr_d = cr_q;
      cc_d = cc_q;
      if (start) begin
        cr_d = '0;
        cc_d = '0;
      end else if (cv[s]) begin
        if (cc_q == CW'(IMG_W - 1)) begin
          cc_d = '0;
          cr_d = cr_q + RW'(1);
        end else begin
          cc_d = cc_q + CW'(1);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cr_q <= '0;
        cc_q <= '0;
      end else if (start || cv[s]) begin
        cr_q <= cr_d;
        cc_q <= cc_d;
      end
    end

    assign edg[s] = '{top: (cr_q == '0),
                      bot: (cr_q == RW'(IMG_H - 1)),
                      lft: (cc_q == '0),
                      rgt: (cc_q == CW'(IMG_W - 1))};
  end

endmodule

// File: rtl/morph_dilate3.sv
module morph_dilate3
  import morph_pkg::*;
#(
  parameter int IMG_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       cv,
  input  edge_t      edg,
  input  logic [8:0] se,
  input  logic       x,
  output logic       o
);

  localparam int SRL = 2 * IMG_W + 2;

  logic [SRL-1:0] sr_q, sr_d;
  logic [8:0]     tap;
  logic           hit, o_q, o_d;

  // sr_q[j] holds the pixel that entered j+1 ticks ago
  for (genvar i = 0; i < 9; i++) begin : g_tap
    localparam int DR = i / 3 - 1;
    localparam int DC = i % 3 - 1;
    localparam int D  = (IMG_W + 1) - DR * IMG_W - DC;
    logic pix;
    if (D == 0) begin : g_new
      assign pix = x;
    end else begin : g_old
      assign pix = sr_q[D-1];
    end
    assign tap[i] = se[i] && pix
                    && !(DR < 0 && edg.top) && !(DR > 0 && edg.bot)
                    && !(DC < 0 && edg.lft) && !(DC > 0 && edg.rgt);
  end

  assign hit  = |tap;
  assign sr_d = {sr_q[SRL-2:0], x};
  assign o_d  = cv ? hit : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      o_q  <= 1'b0;
    end else if (adv) begin
      sr_q <= sr_d;
      o_q  <= o_d;
    end
  end

  assign o = o_q;

endmodule

// File: rtl/morph_seq.sv
module morph_seq
  import morph_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_tag,
  input  logic [8:0] se_mask,
  input  logic       sel_inv,
  input  logic       sel_pair,
  output logic       out_valid,
  output logic       out_tag
);

  localparam int NSTG = NUM_PASS;

  logic [1:0]       rst_pipe;
  logic             rst_int;
  logic             start;
  logic             frm_adv, frm_take, frm_act, frm_feed;
  logic [NSTG-1:0]  cen_ok;
  edge_t [NSTG-1:0] cen_edg;
  logic [NSTG-1:0]  eng_x, eng_o;
  logic [1:0]       sel_q, sel_d;
  logic [8:0]       se_q, se_d;
  logic             inv_now;
  logic             ov_q, ov_d;
  morph_op_e        op;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  assign start   = in_valid & in_sof;
  assign sel_d   = start ? {sel_pair, sel_inv} : sel_q;
  assign se_d    = start ? se_mask : se_q;
  assign inv_now = start ? sel_inv : sel_q[0];
  assign op      = morph_op_e'(sel_q);

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      sel_q <= '0;
      se_q  <= '0;
    end else if (start) begin
      sel_q <= sel_d;
      se_q  <= se_d;
    end
  end

  morph_frame_track #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .NSTG  (NSTG)
  ) u_trk (
    .clk      (clk),
    .rst_n    (rst_int),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .two_pass (sel_q[1]),
    .adv      (frm_adv),
    .take     (frm_take),
    .act      (frm_act),
    .feed     (frm_feed),
    .cv       (cen_ok),
    .edg      (cen_edg)
  );

  assign eng_x[0] = frm_take ? (in_tag ^ inv_now) : 1'b0;

  for (genvar s = 0; s < NSTG; s++) begin : g_pass
    if (s > 0) begin : g_link
      assign eng_x[s] = ~eng_o[s-1];
    end
    morph_dilate3 #(
      .IMG_W (IMG_W)
    ) u_dil (
      .clk   (clk),
      .rst_n (rst_int),
      .adv   (frm_adv),
      .cv    (cen_ok[s]),
      .edg   (cen_edg[s]),
      .se    (se_q),
      .x     (eng_x[s]),
      .o     (eng_o[s])
    );
  end

  assign ov_d = sel_q[1] ? cen_ok[NSTG-1] : cen_ok[0];

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) ov_q <= 1'b0;
    else          ov_q <= ov_d;
  end

  assign out_valid = ov_q;

  always_comb begin
    unique case (op)
      OP_DILATE: out_tag = eng_o[0];
      OP_ERODE:  out_tag = ~eng_o[0];
      OP_CLOSE:  out_tag = ~eng_o[NSTG-1];
      default:   out_tag = eng_o[NSTG-1];
    endcase
  end

endmodule

// File: rtl/morph_seq_chk.sv
module morph_seq_chk #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sof,
  input logic       out_valid,
  input logic       frm_act,
  input logic       frm_feed,
  input logic [1:0] sel_q,
  input logic [8:0] se_q
);

  localparam int NPIX = IMG_W * IMG_H;
  localparam int BCW  = $clog2(NPIX + 1) + 1;

  logic [BCW-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    beats <= '0;
    else if (in_valid && in_sof)   beats <= '0;
    else if (out_valid)            beats <= beats + BCW'(1);
  end

  // R1: no output while reset is applied
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (!out_valid);
  end

  // R7: a frame never yields more beats than it has pixels
  a_r7_beat_cap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (beats < BCW'(NPIX)));

  // R7: output beats only come from a frame in progress
  a_r7_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(frm_act));

  // R8: a missing input beat while pixels are expected stalls the output
  a_r8_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_feed && !in_valid) |=> !out_valid);

  // R9: captured controls hold until the next frame start
  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_act && !(in_valid && in_sof)) |=> $stable({sel_q, se_q}));

endmodule

bind morph_seq morph_seq_chk #(
  .IMG_W (IMG_W),
  .IMG_H (IMG_H)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .frm_act   (frm_act),
  .frm_feed  (frm_feed),
  .sel_q     (sel_q),
  .se_q      (se_q)
);

// File: tb/sim_morph_seq.sv
module sim_morph_seq;

  localparam int BW = 8;
  localparam int BH = 5;
  localparam int NP = BW * BH;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sof, in_tag, sel_inv, sel_pair;
  logic [8:0] se_mask;
  logic       out_valid, out_tag;

  int nchk = 0, nfail = 0;
  int cyc = 0, sof_cyc = 0, first_lat = 0, ncol = 0;
  logic [NP-1:0] got_img;
  bit mark_sof = 0, chg_ctl = 0;

  always #10 clk = ~clk;

  morph_seq #(.IMG_W(BW), .IMG_H(BH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_tag(in_tag), .se_mask(se_mask), .sel_inv(sel_inv),
    .sel_pair(sel_pair), .out_valid(out_valid), .out_tag(out_tag)
  );

  // {sel[1:0], se[8:0], pattern[2:0], gap[1:0]}; expected values come from the model below
  localparam int NV = 13;
  localparam logic [15:0] VT [NV] = '{
    {2'b00, 9'h1FF, 3'd0, 2'd0},
    {2'b00, 9'h0BA, 3'd0, 2'd0},
    {2'b00, 9'h1FF, 3'd1, 2'd0},
    {2'b01, 9'h1FF, 3'd2, 2'd0},
    {2'b01, 9'h0BA, 3'd5, 2'd0},
    {2'b01, 9'h1FF, 3'd4, 2'd1},
    {2'b10, 9'h1FF, 3'd7, 2'd0},
    {2'b10, 9'h0BA, 3'd4, 2'd2},
    {2'b11, 9'h1FF, 3'd7, 2'd0},
    {2'b11, 9'h0BA, 3'd4, 2'd1},
    {2'b00, 9'h006, 3'd3, 2'd0},
    {2'b11, 9'h1FF, 3'd6, 2'd0},
    {2'b01, 9'h030, 3'd4, 2'd0}
  };

  function automatic logic [NP-1:0] gen_img(input int kind, input int salt);
    logic [NP-1:0] im;
    for (int p = 0; p < NP; p++) begin
      int r = p / BW;
      int c = p % BW;
      case (kind)
        0: im[p] = (r == 2 && c == 3);
        1: im[p] = (r == 0 && c == 0) || (r == BH-1 && c == BW-1);
        2: im[p] = (r >= 1 && r <= 3 && c >= 2 && c <= 5);
        3: im[p] = ((r + c) % 2) == 1;
        4: im[p] = (((p * 37 + salt * 11) ^ (p >> 2)) % 5) < 2;
        5: im[p] = 1'b1;
        6: im[p] = 1'b0;
        default: im[p] = ((r >= 1 && r <= 3 && c >= 1 && c <= 4) && !(r == 2 && c == 2))
                         || (r == 0 && c == 6);
      endcase
    end
    return im;
  endfunction

  function automatic logic [NP-1:0] m_dil(input logic [NP-1:0] im, input logic [8:0] se);
    logic [NP-1:0] res;
    for (int p = 0; p < NP; p++) begin
      res[p] = 1'b0;
      for (int i = 0; i < 9; i++) begin
        int rr = p / BW + i / 3 - 1;
        int cc = p % BW + i % 3 - 1;
        if (se[i] && rr >= 0 && rr < BH && cc >= 0 && cc < BW && im[rr*BW+cc]) res[p] = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [NP-1:0] m_op(input logic [NP-1:0] im, input logic [8:0] se,
                                         input logic [1:0] sel);
    case (sel)
      2'b00:   return m_dil(im, se);
      2'b01:   return ~m_dil(~im, se);
      2'b10:   return ~m_dil(~m_dil(im, se), se);
      default: return m_dil(~m_dil(~im, se), se);
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (out_valid) begin
      if (ncol == 0) first_lat = cyc - sof_cyc;
      if (ncol < NP) got_img[ncol] = out_tag;
      ncol++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic t);
    @(posedge clk); #5;
    if (mark_sof) begin
      ncol = 0; sof_cyc = cyc; mark_sof = 0;
      if (chg_ctl) begin
        se_mask = ~se_mask; sel_inv = ~sel_inv; sel_pair = ~sel_pair; chg_ctl = 0;
      end
    end
    in_valid = v; in_sof = s; in_tag = t;
  endtask

  task automatic run_frame(input logic [1:0] sel, input logic [8:0] se,
                           input logic [NP-1:0] img, input int gap, input int salt,
                           input bit noise, input bit chg, input int npix);
    sel_pair = sel[1]; sel_inv = sel[0]; se_mask = se;
    for (int p = 0; p < npix; p++) begin
      int g = 0;
      if (gap == 1 && p % 3 == 1) g = 1;
      if (gap == 2 && (p * 7 + salt) % 4 == 0) g = 2;
      for (int k = 0; k < g; k++) step(1'b0, 1'b0, 1'b0);
      step(1'b1, (p == 0), img[p]);
      if (p == 0) begin mark_sof = 1; chg_ctl = chg; end
    end
    if (npix == NP) begin
      for (int w = 0; w < 400 && (ncol < NP || mark_sof); w++) step(noise, 1'b0, 1'b1);
      for (int w = 0; w < 4; w++) step(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic frame_checks(input logic [1:0] sel, input logic [8:0] se,
                              input logic [NP-1:0] img, input string req, input bit lat_chk);
    logic [NP-1:0] exp = m_op(img, se, sel);
    chk(ncol == NP, "R7", "beat count", ncol, NP);
    chk(got_img == exp, req, "mask", got_img, exp);
    if (lat_chk)
      chk(first_lat == (sel[1] ? 2*BW+3 : BW+1), "R7", "first beat latency",
          first_lat, sel[1] ? 2*BW+3 : BW+1);
  endtask

  initial begin
    rst_n = 1'b1; in_valid = 0; in_sof = 0; in_tag = 0;
    sel_inv = 0; sel_pair = 0; se_mask = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5 chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0);
    chk(out_valid == 1'b0 && ncol == 0, "R1", "out_valid after release", ncol, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0] sl = VT[v][15:14];
      logic [8:0] se = VT[v][13:5];
      int pat = int'(VT[v][4:2]);
      int gp = int'(VT[v][1:0]);
      logic [NP-1:0] img = gen_img(pat, v);
      string rq;
      case (sl)
        2'b00: rq = "R2";
        2'b01: rq = "R3";
        2'b10: rq = "R4";
        default: rq = "R5";
      endcase
      if (pat == 1 || pat == 5) rq = {rq, "/R6"};
      if (gp != 0) rq = {rq, "/R8"};
      run_frame(sl, se, img, gp, v, 1'b0, 1'b0, NP);
      frame_checks(sl, se, img, rq, gp == 0);
    end

    // R11: stray beats while idle produce nothing
    ncol = 0;
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 30; k++) step(1'b0, 1'b0, 1'b0);
    chk(ncol == 0, "R11", "idle stray beats", ncol, 0);

    // R11: noise beats during flush are ignored
    begin
      logic [NP-1:0] im = gen_img(4, 21);
      run_frame(2'b10, 9'h1FF, im, 0, 21, 1'b1, 1'b0, NP);
      frame_checks(2'b10, 9'h1FF, im, "R11", 1'b1);
    end

    // R9: controls flipped right after frame start
    begin
      logic [NP-1:0] im = gen_img(7, 3);
      run_frame(2'b01, 9'h0BA, im, 0, 3, 1'b0, 1'b1, NP);
      frame_checks(2'b01, 9'h0BA, im, "R9", 1'b1);
    end

    // R10: abandon a frame part way, restart with another operator
    begin
      logic [NP-1:0] im_a = gen_img(5, 0);
      logic [NP-1:0] im_b = gen_img(4, 9);
      run_frame(2'b00, 9'h1FF, im_a, 0, 0, 1'b0, 1'b0, 15);
      run_frame(2'b11, 9'h0BA, im_b, 0, 9, 1'b0, 1'b0, NP);
      frame_checks(2'b11, 9'h0BA, im_b, "R10", 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule